// File: doc/BRIEF.md
# Write-Once Chip Configuration Register Block

This block holds the chip-level configuration state behind a small 32-bit register port. A 16-bit configuration register drives the configuration outputs. Each of its bits locks after its first write in normal operation. While the debug input is high, or once the internal test flag has been set, every bit accepts any number of writes. A bit written in those modes is left unlocked, so it stays writable after the mode ends. Leaving debug does not reload or reset the register; the outputs keep whatever value it holds.

A 16-bit reset-configuration register is captured on every clock while reset is held, so the value present on the final reset cycle is the one kept. The override input selects the source. When it is high, the levels of the mode, boot-device and module-configuration pins are used. When it is low, a fixed default is used. After reset the register is read-only. A constant identification value sits beside it. A reserved word always reads zero, and a nonzero write to it raises a sticky test flag.

Each access takes two clocks through a three-state machine. ST_IDLE accepts a request. It moves to ST_ACK (transition *accept*) for a legal supervisor access to a mapped word. It moves to ST_ERR (transition *reject*) for any other request. Both ST_ACK and ST_ERR return to ST_IDLE on the next clock (transition *retire*). Requests that arrive outside ST_IDLE are not taken.

Top module: `cfg_lock_regs`

## Requirements
- R1: After reset the configuration register holds CFG_RST (default 16'h0005), every bit is unlocked, the test flag is low, and both ack and terr are low.
- R2: The reset-configuration register is loaded on each clock while rst_n is low and is frozen afterwards. With rc_ovr high it becomes {5'b0, rc_mode[2:0], 3'b0, rc_boot, rc_misc[3:0]}. With rc_ovr low it becomes RCON_DFLT (default 16'h0521).
- R3: A request is taken in ST_IDLE on a rising edge. In the following cycle, exactly one of ack or terr is high, for one cycle only. rdata carries the read word while ack is high after a read, and is zero in every other response.
- R4: The word address is addr[7:2]. Word 1 reads {cfg, 16'h0}. Word 2 reads {rcon, ID_VAL}, where ID_VAL defaults to 16'h5A31. Word 3 reads zero. Any other word gives terr.
- R5: In normal operation, the first write to a configuration bit sets its value and locks it. Later writes to a locked bit leave it unchanged and still complete with ack.
- R6: size encodes 0 as byte, 1 as halfword and 2 as word. The byte lane for byte offset k is wdata bits [31-8k -: 8]. A halfword at addr[1]=0 uses lanes [31:16]; at addr[1]=1 it uses lanes [15:0]. Only configuration bits in enabled lanes are written or locked. size 3, a halfword with addr[0]=1, and a word with addr[1:0]!=0 give terr and change nothing.
- R7: While dbg_mode is high, configuration bits take every write regardless of lock. A bit written this way is unlocked, so its next normal write takes effect.
- R8: A change of dbg_mode on its own never changes cfg_q.
- R9: A request with sup low gives terr and changes no register or flag.
- R10: A write to word 3 whose enabled lanes carry a nonzero value sets tst_flag. A zero write leaves it unchanged. tst_flag stays set until reset and unlocks the configuration bits as dbg_mode does.
- R11: Writes to word 2 complete with ack and change neither rcon nor the identification value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rc_ovr | input | 1 | Reset-configuration override select |
| rc_mode | input | 3 | Chip-mode pins sampled during reset |
| rc_boot | input | 1 | Boot-device pin sampled during reset |
| rc_misc | input | 4 | Clock-mode and module-configuration pins sampled during reset |
| dbg_mode | input | 1 | Debug mode active |
| req | input | 1 | Access request |
| wr | input | 1 | 1 = write, 0 = read |
| sup | input | 1 | 1 = supervisor access, 0 = user access |
| addr | input | 8 | Byte address |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while ack is high |
| ack | output | 1 | Normal completion |
| terr | output | 1 | Transfer-error completion |
| cfg_q | output | 16 | Current configuration register value |
| rcon_q | output | 16 | Reset-configuration value |
| tst_flag | output | 1 | Sticky test-mode flag |

## Verification
A lock flag is internal, so a wrong one shows only on the next write to its bit. That write then either changes cfg_q when it should not, or fails to change it when it should, one cycle after the accepting edge. The bench therefore writes the same bits again after each locking, debug and test step. A wrong machine state shows as ack or terr in the wrong cycle, or both at once, on the cycle after the request. The reference model compares cfg_q, rcon_q, tst_flag, ack and terr on every clock, so any divergence is reported in the cycle it appears.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_ERR  = 2'd2
    } bus_st_t;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // byte lanes touched by an access; lane 3 is bits 31:24 (offset 0)
    function automatic logic [3:0] lane_en(input logic [1:0] sz, input logic [1:0] lo);
        logic [3:0] en;
        unique case (sz)
            SZ_BYTE: en = 4'b1000 >> lo;
            SZ_HALF: en = lo[1] ? 4'b0011 : 4'b1100;
            SZ_WORD: en = 4'b1111;
            default: en = 4'b0000;
        endcase
        return en;
    endfunction

    function automatic logic aligned(input logic [1:0] sz, input logic [1:0] lo);
        logic ok;
        unique case (sz)
            SZ_BYTE: ok = 1'b1;
            SZ_HALF: ok = ~lo[0];
            SZ_WORD: ok = (lo == 2'b00);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/cfg_rst_sample.sv
module cfg_rst_sample #(
    parameter logic [15:0] DFLT = 16'h0521
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ovr,
    input  logic [2:0]  mode_pins,
    input  logic        boot_pin,
    input  logic [3:0]  misc_pins,
    output logic [15:0] rcon_q
);

    logic [15:0] sampled;

    always_comb begin
        sampled = {5'b0, mode_pins, 3'b0, boot_pin, misc_pins};
    end

    // keeps reloading while reset is held; the final reset cycle wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcon_q <= ovr ? sampled : DFLT;
        end
    end

    assert_rcon_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(rcon_q));

endmodule

// File: rtl/cfg_wo_bits.sv
module cfg_wo_bits #(
    parameter int          W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         unlock,
    input  logic [W-1:0] wmask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] lk;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i]  <= RST_VAL[i];
                lk[i] <= 1'b0;
            end else if (wmask[i]) begin
                if (unlock) begin
                    q[i]  <= wdata[i];
                    lk[i] <= 1'b0;
                end else if (!lk[i]) begin
                    q[i]  <= wdata[i];
                    lk[i] <= 1'b1;
                end
            end
        end

        assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!unlock && lk[i]) |=> $stable(q[i]));

        assert_first_locks_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!unlock && wmask[i]) |=> lk[i]);

        assert_dbg_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (unlock && wmask[i]) |=> (q[i] == $past(wdata[i])));
    end

endmodule

// File: rtl/cfg_bus_fsm.sv
module cfg_bus_fsm
    import cfg_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter logic [15:0] ID_VAL = 16'h5A31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic              sup,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [31:0]       wdata,
    input  logic [15:0]       cfg_q,
    input  logic [15:0]       rcon_q,
    output logic [31:0]       rdata,
    output logic              ack,
    output logic              terr,
    output logic [15:0]       cfg_wmask,
    output logic              tst_set
);

    localparam int WA_W = ADDR_W - 2;
    localparam logic [WA_W-1:0] W_CFG = WA_W'(1);
    localparam logic [WA_W-1:0] W_RCF = WA_W'(2);
    localparam logic [WA_W-1:0] W_RSV = WA_W'(3);

    bus_st_t         st, nxt;
    logic [3:0]      lanes;
    logic [31:0]     mask32;
    logic [WA_W-1:0] wa;
    logic            take, hit, good, bad;
    logic [31:0]     rd_q, rd_val;

    assign wa    = addr[ADDR_W-1:2];
    assign lanes = lane_en(size, addr[1:0]);

    for (genvar b = 0; b < 32; b++) begin : g_mask
        assign mask32[b] = lanes[b/8];
    end

    always_comb begin
        take = (st == ST_IDLE) && req;
        hit  = (wa == W_CFG) || (wa == W_RCF) || (wa == W_RSV);
        good = take && sup && aligned(size, addr[1:0]) && hit;
        bad  = take && !good;
        cfg_wmask = (good && wr && wa == W_CFG) ? mask32[31:16] : 16'h0;
        tst_set   = good && wr && (wa == W_RSV) && (|(wdata & mask32));
        if (wa == W_CFG)      rd_val = {cfg_q, 16'h0};
        else if (wa == W_RCF) rd_val = {rcon_q, ID_VAL};
        else                  rd_val = 32'h0;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (good) nxt = ST_ACK;
                     else if (bad) nxt = ST_ERR;
            ST_ACK:  nxt = ST_IDLE;
            ST_ERR:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            rd_q <= 32'h0;
        end else begin
            st   <= nxt;
            rd_q <= (good && !wr) ? rd_val : 32'h0;
        end
    end

    always_comb begin
        ack   = (st == ST_ACK);
        terr  = (st == ST_ERR);
        rdata = rd_q;
    end

    assert_resp_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack, terr}));

    assert_resp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack || terr) |=> !(ack || terr));

    assert_user_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && req && !sup) |=> terr);

    assert_no_user_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sup |-> (cfg_wmask == 16'h0 && !tst_set));

endmodule

// File: rtl/cfg_lock_regs.sv
module cfg_lock_regs #(
    parameter int          ADDR_W    = 8,
    parameter logic [15:0] CFG_RST   = 16'h0005,
    parameter logic [15:0] RCON_DFLT = 16'h0521,
    parameter logic [15:0] ID_VAL    = 16'h5A31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rc_ovr,
    input  logic [2:0]        rc_mode,
    input  logic              rc_boot,
    input  logic [3:0]        rc_misc,
    input  logic              dbg_mode,
    input  logic              req,
    input  logic              wr,
    input  logic              sup,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              ack,
    output logic              terr,
    output logic [15:0]       cfg_q,
    output logic [15:0]       rcon_q,
    output logic              tst_flag
);

    logic [15:0] cfg_wmask;
    logic        tst_set;
    logic        tst_q;

    cfg_rst_sample #(.DFLT(RCON_DFLT)) u_sample (
        .clk(clk), .rst_n(rst_n), .ovr(rc_ovr),
        .mode_pins(rc_mode), .boot_pin(rc_boot), .misc_pins(rc_misc),
        .rcon_q(rcon_q)
    );

    cfg_bus_fsm #(.ADDR_W(ADDR_W), .ID_VAL(ID_VAL)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .sup(sup),
        .addr(addr), .size(size), .wdata(wdata),
        .cfg_q(cfg_q), .rcon_q(rcon_q),
        .rdata(rdata), .ack(ack), .terr(terr),
        .cfg_wmask(cfg_wmask), .tst_set(tst_set)
    );

    cfg_wo_bits #(.W(16), .RST_VAL(CFG_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .unlock(dbg_mode | tst_q),
        .wmask(cfg_wmask), .wdata(wdata[31:16]), .q(cfg_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       tst_q <= 1'b0;
        else if (tst_set) tst_q <= 1'b1;
    end

    assign tst_flag = tst_q;

    assert_tst_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tst_q |=> tst_q);

    assert_dbg_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wmask == 16'h0) |=> $stable(cfg_q));

endmodule

// File: tb/cfg_lock_regs_bench.sv
module cfg_lock_regs_bench;

    localparam int CLK_P = 10;

    logic        clk = 0, rst_n = 0;
    logic        rc_ovr = 0, rc_boot = 0, dbg_mode = 0;
    logic [2:0]  rc_mode = 0;
    logic [3:0]  rc_misc = 0;
    logic        req = 0, wr = 0, sup = 1;
    logic [7:0]  addr = 0;
    logic [1:0]  size = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic        ack, terr, tst_flag;
    logic [15:0] cfg_q, rcon_q;

    int checks = 0, fails = 0;
    bit done = 0, run = 0;

    // reference model
    logic [15:0] m_cfg, m_lck, m_rcon;
    bit          m_tst, e_ack, e_terr;

    cfg_lock_regs u_cfg_lock_regs (
        .clk(clk), .rst_n(rst_n), .rc_ovr(rc_ovr), .rc_mode(rc_mode),
        .rc_boot(rc_boot), .rc_misc(rc_misc), .dbg_mode(dbg_mode),
        .req(req), .wr(wr), .sup(sup), .addr(addr), .size(size),
        .wdata(wdata), .rdata(rdata), .ack(ack), .terr(terr),
        .cfg_q(cfg_q), .rcon_q(rcon_q), .tst_flag(tst_flag)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (run && rst_n) begin
            chk("R8 cfg_q", {16'h0, cfg_q}, {16'h0, m_cfg});
            chk("R2 rcon_q", {16'h0, rcon_q}, {16'h0, m_rcon});
            chk("R10 tst_flag", {31'h0, tst_flag}, {31'h0, m_tst});
            chk("R3 ack", {31'h0, ack}, {31'h0, e_ack});
            chk("R3 terr", {31'h0, terr}, {31'h0, e_terr});
        end
    end

    task automatic do_reset(input bit ovr, input logic [2:0] md, input bit bt, input logic [3:0] ms);
        @(negedge clk);
        run = 0; rst_n = 0; req = 0;
        rc_ovr = ovr; rc_mode = md; rc_boot = bt; rc_misc = ms;
        repeat (3) @(negedge clk);
        m_cfg = 16'h0005; m_lck = 16'h0; m_tst = 0; e_ack = 0; e_terr = 0;
        m_rcon = ovr ? {5'b0, md, 3'b0, bt, ms} : 16'h0521;
        rst_n = 1;
        // R1: reset state
        chk("R1 cfg reset", {16'h0, cfg_q}, 32'h0005);
        chk("R1 ack/terr/tst idle", {29'h0, ack, terr, tst_flag}, 32'h0);
        rc_ovr = ~ovr; rc_mode = ~md; rc_boot = ~bt; rc_misc = ~ms;
        run = 1;
    endtask

    task automatic access(input bit w, input bit s, input logic [7:0] a,
                          input logic [1:0] sz, input logic [31:0] d, input string tag);
        logic [3:0]  en;
        logic [31:0] m32, exp_rd;
        bit          err, unl;
        int          wi;
        en = 4'b0000;
        if (sz == 2'd0) en[3 - a[1:0]] = 1'b1;
        else if (sz == 2'd1) en = a[1] ? 4'b0011 : 4'b1100;
        else if (sz == 2'd2) en = 4'b1111;
        for (int b = 0; b < 32; b++) m32[b] = en[b / 8];
        wi  = a[7:2];
        err = !s || sz == 2'd3 || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 0)
              || !(wi == 1 || wi == 2 || wi == 3);
        exp_rd = 32'h0;
        if (!err && !w) begin
            if (wi == 1) exp_rd = {m_cfg, 16'h0};
            else if (wi == 2) exp_rd = {m_rcon, 16'h5A31};
        end
        @(negedge clk);
        req = 1; wr = w; sup = s; addr = a; size = sz; wdata = d;
        @(posedge clk);
        #1;
        unl = dbg_mode || m_tst;
        if (!err && w && wi == 1) begin
            for (int i = 0; i < 16; i++) begin
                if (m32[i + 16]) begin
                    if (unl) begin
                        m_cfg[i] = d[i + 16]; m_lck[i] = 1'b0;
                    end else if (!m_lck[i]) begin
                        m_cfg[i] = d[i + 16]; m_lck[i] = 1'b1;
                    end
                end
            end
        end
        if (!err && w && wi == 3 && (d & m32) != 0) m_tst = 1;
        e_ack = !err; e_terr = err;
        @(negedge clk);
        req = 0;
        chk({tag, " response"}, {30'h0, ack, terr}, {30'h0, !err, err});
        chk({tag, " rdata"}, rdata, exp_rd);
        @(posedge clk);
        #1;
        e_ack = 0; e_terr = 0;
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset(1, 3'b101, 1'b1, 4'b0011);
        chk("R2 override capture", {16'h0, rcon_q}, 32'h0513);
        // R4 address map
        access(0, 1, 8'h08, 2'd2, 0, "R4 read rcon/id");
        access(0, 1, 8'h04, 2'd2, 0, "R4 read cfg");
        access(0, 1, 8'h0C, 2'd2, 0, "R4 read reserved");
        access(0, 1, 8'h00, 2'd2, 0, "R4 unmapped 0x0");
        access(0, 1, 8'h10, 2'd2, 0, "R4 unmapped 0x10");
        // R6 byte lanes then R5 locking
        access(1, 1, 8'h04, 2'd0, 32'h3C00_0000, "R6 byte write");
        access(1, 1, 8'h04, 2'd2, 32'hFFFF_FFFF, "R5 word over locked byte");
        access(1, 1, 8'h04, 2'd1, 32'h1234_0000, "R5 locked half");
        access(0, 1, 8'h04, 2'd1, 0, "R5 read back");
        access(1, 1, 8'h05, 2'd1, 32'h0, "R6 misaligned half");
        access(1, 1, 8'h06, 2'd2, 32'h0, "R6 misaligned word");
        access(1, 1, 8'h04, 2'd3, 32'h0, "R6 size 3");
        // R9 user mode
        access(1, 0, 8'h04, 2'd2, 32'h0, "R9 user write");
        access(0, 0, 8'h08, 2'd2, 0, "R9 user read");
        access(1, 0, 8'h0C, 2'd2, 32'hFFFF_FFFF, "R9 user reserved write");
        // R7 debug
        @(negedge clk); dbg_mode = 1;
        access(1, 1, 8'h04, 2'd2, 32'h0000_0000, "R7 debug write");
        access(1, 1, 8'h04, 2'd2, 32'h1111_0000, "R7 debug rewrite");
        @(negedge clk); dbg_mode = 0;
        repeat (2) @(negedge clk);   // R8 checked by monitor
        access(1, 1, 8'h04, 2'd2, 32'hABCD_0000, "R7 writable after debug");
        access(1, 1, 8'h04, 2'd2, 32'h0000_0000, "R5 relocked");
        // R11 read-only word
        access(1, 1, 8'h08, 2'd2, 32'hFFFF_FFFF, "R11 rcon/id write");
        access(0, 1, 8'h08, 2'd2, 0, "R11 rcon/id unchanged");
        // R10 reserved word
        access(1, 1, 8'h0C, 2'd2, 32'h0, "R10 zero write");
        access(1, 1, 8'h0C, 2'd0, 32'h00FF_FFFF, "R10 nonzero outside lane");
        access(1, 1, 8'h0F, 2'd0, 32'h0000_0001, "R10 nonzero byte");
        access(1, 1, 8'h04, 2'd2, 32'h7777_0000, "R10 unlock by test");
        access(1, 1, 8'h04, 2'd1, 32'h0F0F_0000, "R10 rewrite by test");
        chk("R10 cfg after test writes", {16'h0, cfg_q}, 32'h0F0F);
        // R2 default path, R1 second reset
        do_reset(0, 3'b010, 1'b0, 4'b1100);
        chk("R2 default capture", {16'h0, rcon_q}, 32'h0521);
        access(1, 1, 8'h04, 2'd2, 32'h8001_0000, "R1 unlocked after reset");
        access(1, 1, 8'h04, 2'd2, 32'h0000_0000, "R5 locked after reset write");
        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule